// File: doc/BRIEF.md
# Decade Results Counter with Range Flags

This block holds the running result of a multi-phase integrating conversion as a sign plus a six-decade BCD magnitude. A sequencer asserts a count enable while the zero-crossing comparator has not yet tripped. It also picks a direction and the decade position at which each enabled cycle adds or removes one unit. Coarse phases count at a high decade and later refinement phases count at lower ones. Carries and borrows ripple through the decades. Counting down past zero flips the sign and continues as a magnitude, which is what a refinement phase needs when it overshoots.

The visible reading is the magnitude with its lowest decade dropped. That decade is used only to round the displayed five digits half-up. A display latch takes the reading and the over-range and under-range flags at an end-of-conversion strobe. A two-bit hold mode selects one of three behaviours. In run mode the latch updates at each strobe. In hold mode it freezes. In follow mode it tracks the counter on every cycle, while the flags still wait for a strobe.

Top module: `decade_result_counter`

## Requirements
- R1: After reset the displayed digits are all zero, and the sign, the over-range flag and the under-range flag are all low.
- R2: `clr` high at a clock edge sets the magnitude to zero and the sign to positive. This takes priority over a count enabled in the same cycle.
- R3: With `cnt_en` high and `cnt_dn` low, each clock edge adds 10^`dec_sel` to the magnitude, and carries ripple into the higher decades.
- R4: With `cnt_en` high, `cnt_dn` high and a magnitude of at least 10^`dec_sel`, each edge subtracts 10^`dec_sel`, and borrows ripple through the higher decades.
- R5: A down count at position k applied to a magnitude below 10^k replaces the magnitude with 10^k minus the old magnitude and inverts the sign.
- R6: With `cnt_en` low, or with `dec_sel` at or above the number of decades, the sign and the magnitude do not change, whatever the other inputs are.
- R7: An up count whose result would exceed 999999 leaves the counter unchanged.
- R8: Display digit i (`disp_bcd[4i+3:4i]`) is counter decade i+1. The five digits are rounded up by one when counter decade 0 is 5 or more, and the rounding saturates at 99999.
- R9: `over_flag` is set when the rounded reading is above 19999, that is, when its top digit is 2 or more. `under_flag` is set when the rounded reading is below 1000, that is, when its top two digits are zero.
- R10: In run mode (`hold_mode` 00 or 11), an edge with `latch_stb` high captures the digits, the sign and both flags. Without a strobe the latched outputs stay stable.
- R11: In hold mode (`hold_mode` 01), the digits, the sign and the flags never change, and strobes are ignored.
- R12: In follow mode (`hold_mode` 10), the digits and the sign are copied from the counter on every edge. The flags change only on an edge with `latch_stb` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the counter |
| cnt_en | input | 1 | Count one step this cycle |
| cnt_dn | input | 1 | Direction: 0 up, 1 down |
| dec_sel | input | 3 | Decade position of the step |
| latch_stb | input | 1 | End-of-conversion capture strobe |
| hold_mode | input | 2 | 00/11 run, 01 hold, 10 follow |
| disp_bcd | output | 20 | Latched rounded BCD reading, digit 0 lowest |
| disp_neg | output | 1 | Latched sign, 1 is negative |
| over_flag | output | 1 | Latched over-range flag |
| under_flag | output | 1 | Latched under-range flag |

## Verification
A counter step lands on the clock edge that samples `cnt_en`. In follow mode the display shows that step one edge later. A strobe capture is visible right after the edge that sampled `latch_stb` high. The bench changes inputs on falling edges and samples outputs on the falling edge after the last edge that is due. It compares each sample with a magnitude-and-sign model that rounds and sets flags on its own. Hold-mode and flag-wait checks read the latched outputs after a count and a strobe have been applied, then release the mode and confirm that the captured value really changes.

// File: rtl/rcnt_pkg.sv
package rcnt_pkg;

   typedef enum logic [1:0] {
      HM_RUN     = 2'b00,
      HM_HOLD    = 2'b01,
      HM_FOLLOW  = 2'b10,
      HM_RUN_ALT = 2'b11
   } hold_mode_e;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_UP   = 2'd1,
      OP_DOWN = 2'd2,
      OP_CPL  = 2'd3
   } step_op_e;

   function automatic logic [3:0] bcd_inc(input logic [3:0] d);
      return (d == 4'd9) ? 4'd0 : d + 4'd1;
   endfunction

   function automatic logic [3:0] bcd_dec(input logic [3:0] d);
      return (d == 4'd0) ? 4'd9 : d - 4'd1;
   endfunction

endpackage

// File: rtl/rcnt_decade.sv
module rcnt_decade
   import rcnt_pkg::*;
(
   input  logic [3:0] dig_i,
   input  step_op_e   op_i,
   input  logic       at_step_i,
   input  logic       below_i,
   input  logic       chain_i,
   output logic [3:0] dig_o,
   output logic       chain_o
);

   logic       act;
   logic [3:0] cval;

   always_comb begin
      dig_o   = dig_i;
      chain_o = 1'b0;
      act     = 1'b0;
      cval    = 4'd9 - dig_i;
      case (op_i)
         OP_UP: begin
            act = !below_i && (at_step_i || chain_i);
            if (act) dig_o = bcd_inc(dig_i);
            chain_o = act && (dig_i == 4'd9);
         end
         OP_DOWN: begin
            act = !below_i && (at_step_i || chain_i);
            if (act) dig_o = bcd_dec(dig_i);
            chain_o = act && (dig_i == 4'd0);
         end
         OP_CPL: begin
            if (below_i) begin
               dig_o   = chain_i ? bcd_inc(cval) : cval;
               chain_o = chain_i && (cval == 4'd9);
            end else if (at_step_i) begin
               dig_o = {3'b000, chain_i};
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/rcnt_core.sv
module rcnt_core
   import rcnt_pkg::*;
#(
   parameter int NUM_DEC = 6,
   localparam int SEL_W = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr,
   input  logic                      cnt_en,
   input  logic                      cnt_dn,
   input  logic [SEL_W-1:0]          dec_sel,
   output logic [NUM_DEC-1:0][3:0]   mag_o,
   output logic                      neg_o
);

   logic [NUM_DEC-1:0][3:0] mag_q;
   logic [NUM_DEC-1:0][3:0] nxt;
   logic                    neg_q;
   logic [NUM_DEC:0]        chain;
   logic [NUM_DEC-1:0]      at_step;
   logic [NUM_DEC-1:0]      below;
   logic                    sel_ok;
   logic                    hi_zero;
   logic                    ovf;
   step_op_e                op;

   assign sel_ok = (32'(dec_sel) < NUM_DEC);

   always_comb begin
      hi_zero = 1'b1;
      for (int i = 0; i < NUM_DEC; i++) begin
         if (!below[i] && (mag_q[i] != 4'd0)) hi_zero = 1'b0;
      end
   end

   always_comb begin
      if (!cnt_en || !sel_ok) op = OP_IDLE;
      else if (!cnt_dn)       op = OP_UP;
      else if (hi_zero)       op = OP_CPL;
      else                    op = OP_DOWN;
   end

   assign chain[0] = (op == OP_CPL);

   for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
      assign at_step[i] = (dec_sel == SEL_W'(i));
      assign below[i]   = (SEL_W'(i) < dec_sel);
      rcnt_decade u_cell (
         .dig_i     (mag_q[i]),
         .op_i      (op),
         .at_step_i (at_step[i]),
         .below_i   (below[i]),
         .chain_i   (chain[i]),
         .dig_o     (nxt[i]),
         .chain_o   (chain[i+1])
      );
      assert_bcd_digit_R3: assert property (@(posedge clk) disable iff (!rst_n)
         mag_q[i] <= 4'd9);
   end

   assign ovf = (op == OP_UP) && chain[NUM_DEC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mag_q <= '0;
         neg_q <= 1'b0;
      end else if (clr) begin
         mag_q <= '0;
         neg_q <= 1'b0;
      end else if (op != OP_IDLE && !ovf) begin
         mag_q <= nxt;
         if (op == OP_CPL) neg_q <= ~neg_q;
      end
   end

   assign mag_o = mag_q;
   assign neg_o = neg_q;

   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (mag_q == '0) && !neg_q);

   assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && (!cnt_en || !sel_ok)) |=> $stable(mag_q) && $stable(neg_q));

   assert_sign_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && op == OP_CPL) |=> (neg_q != $past(neg_q)));

   assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && ovf) |=> $stable(mag_q) && $stable(neg_q));

   assert_down_keeps_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && op == OP_DOWN) |=> $stable(neg_q));

endmodule

// File: rtl/rcnt_round.sv
module rcnt_round
   import rcnt_pkg::*;
#(
   parameter int NUM_DEC = 6,
   localparam int DISP_DEC = NUM_DEC - 1
) (
   input  logic [NUM_DEC-1:0][3:0]  mag_i,
   output logic [DISP_DEC-1:0][3:0] disp_o,
   output logic                     over_o,
   output logic                     under_o
);

   logic [DISP_DEC:0]        rc;
   logic [DISP_DEC-1:0][3:0] upper;
   logic [DISP_DEC-1:0][3:0] bumped;

   assign rc[0] = (mag_i[0] >= 4'd5);

   for (genvar j = 0; j < DISP_DEC; j++) begin : g_rnd
      assign upper[j] = mag_i[j+1];
      rcnt_decade u_inc (
         .dig_i     (upper[j]),
         .op_i      (OP_UP),
         .at_step_i (1'b0),
         .below_i   (1'b0),
         .chain_i   (rc[j]),
         .dig_o     (bumped[j]),
         .chain_o   (rc[j+1])
      );
   end

   assign disp_o  = rc[DISP_DEC] ? upper : bumped;
   assign over_o  = (disp_o[DISP_DEC-1] >= 4'd2);
   assign under_o = (disp_o[DISP_DEC-1] == 4'd0) && (disp_o[DISP_DEC-2] == 4'd0);

endmodule

// File: rtl/rcnt_latch.sv
module rcnt_latch
   import rcnt_pkg::*;
#(
   parameter int DISP_DEC = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  hold_mode_e                mode_i,
   input  logic                      stb_i,
   input  logic [DISP_DEC-1:0][3:0]  disp_i,
   input  logic                      neg_i,
   input  logic                      over_i,
   input  logic                      under_i,
   output logic [DISP_DEC-1:0][3:0]  disp_o,
   output logic                      neg_o,
   output logic                      over_o,
   output logic                      under_o
);

   logic cap_all;
   logic follow;

   assign cap_all = stb_i && (mode_i != HM_HOLD);
   assign follow  = (mode_i == HM_FOLLOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disp_o  <= '0;
         neg_o   <= 1'b0;
         over_o  <= 1'b0;
         under_o <= 1'b0;
      end else begin
         if (cap_all || follow) begin
            disp_o <= disp_i;
            neg_o  <= neg_i;
         end
         if (cap_all) begin
            over_o  <= over_i;
            under_o <= under_i;
         end
      end
   end

   assert_hold_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == HM_HOLD) |=> $stable(disp_o) && $stable(neg_o)
                              && $stable(over_o) && $stable(under_o));

   assert_run_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i == HM_RUN || mode_i == HM_RUN_ALT) && !stb_i)
         |=> $stable(disp_o) && $stable(neg_o));

   assert_flags_on_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_i |=> $stable(over_o) && $stable(under_o));

   assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(over_o && under_o));

endmodule

// File: rtl/decade_result_counter.sv
module decade_result_counter
   import rcnt_pkg::*;
#(
   parameter int NUM_DEC = 6,
   localparam int SEL_W = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1,
   localparam int DISP_DEC = NUM_DEC - 1,
   localparam int DISP_W = DISP_DEC * 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              cnt_en,
   input  logic              cnt_dn,
   input  logic [SEL_W-1:0]  dec_sel,
   input  logic              latch_stb,
   input  logic [1:0]        hold_mode,
   output logic [DISP_W-1:0] disp_bcd,
   output logic              disp_neg,
   output logic              over_flag,
   output logic              under_flag
);

   if (NUM_DEC < 3) begin : g_bad_dec
      $error("decade_result_counter: NUM_DEC must be at least 3");
   end

   logic [NUM_DEC-1:0][3:0]  mag;
   logic                     neg;
   logic [DISP_DEC-1:0][3:0] live_disp;
   logic                     live_over;
   logic                     live_under;
   logic [DISP_DEC-1:0][3:0] lat_disp;

   rcnt_core #(.NUM_DEC(NUM_DEC)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .cnt_en  (cnt_en),
      .cnt_dn  (cnt_dn),
      .dec_sel (dec_sel),
      .mag_o   (mag),
      .neg_o   (neg)
   );

   rcnt_round #(.NUM_DEC(NUM_DEC)) u_round (
      .mag_i   (mag),
      .disp_o  (live_disp),
      .over_o  (live_over),
      .under_o (live_under)
   );

   rcnt_latch #(.DISP_DEC(DISP_DEC)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_i  (hold_mode_e'(hold_mode)),
      .stb_i   (latch_stb),
      .disp_i  (live_disp),
      .neg_i   (neg),
      .over_i  (live_over),
      .under_i (live_under),
      .disp_o  (lat_disp),
      .neg_o   (disp_neg),
      .over_o  (over_flag),
      .under_o (under_flag)
   );

   assign disp_bcd = lat_disp;

endmodule

// File: tb/decade_result_counter_bench.sv
`timescale 1ns/1ps
module decade_result_counter_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        cnt_en = 1'b0;
   logic        cnt_dn = 1'b0;
   logic [2:0]  dec_sel = 3'd0;
   logic        latch_stb = 1'b0;
   logic [1:0]  hold_mode = 2'b00;
   logic [19:0] disp_bcd;
   logic        disp_neg;
   logic        over_flag;
   logic        under_flag;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;
   int  m_mag = 0;
   bit  m_neg = 1'b0;

   always #5 clk = ~clk;

   decade_result_counter u_decade_result_counter (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cnt_en(cnt_en), .cnt_dn(cnt_dn),
      .dec_sel(dec_sel), .latch_stb(latch_stb), .hold_mode(hold_mode),
      .disp_bcd(disp_bcd), .disp_neg(disp_neg),
      .over_flag(over_flag), .under_flag(under_flag)
   );

   function automatic int pow10(input int k);
      int r = 1;
      for (int i = 0; i < k; i++) r = r * 10;
      return r;
   endfunction

   function automatic logic [19:0] to_bcd(input int v);
      logic [19:0] b = '0;
      int t = v;
      for (int i = 0; i < 5; i++) begin
         b[4*i +: 4] = 4'(t % 10);
         t = t / 10;
      end
      return b;
   endfunction

   function automatic int rounded(input int mag);
      int u = mag / 10;
      if ((mag % 10) >= 5 && u < 99999) u = u + 1;
      return u;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic void model_step(input bit dn, input int sel);
      int s;
      if (sel > 5) return;
      s = pow10(sel);
      if (!dn) begin
         if (m_mag + s <= 999999) m_mag = m_mag + s;
      end else if (m_mag >= s) begin
         m_mag = m_mag - s;
      end else begin
         m_mag = s - m_mag;
         m_neg = !m_neg;
      end
   endfunction

   task automatic count(input bit dn, input int sel, input int n);
      @(negedge clk);
      cnt_en = 1'b1; cnt_dn = dn; dec_sel = 3'(sel);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         model_step(dn, sel);
      end
      cnt_en = 1'b0;
   endtask

   task automatic do_clear();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      m_mag = 0; m_neg = 1'b0;
   endtask

   task automatic strobe();
      @(negedge clk); latch_stb = 1'b1;
      @(negedge clk); latch_stb = 1'b0;
   endtask

   // follow mode: display shows the counter one edge after it changed
   task automatic check_follow(input string req);
      @(negedge clk);
      chk({req, " digits"}, 32'(disp_bcd), 32'(to_bcd(rounded(m_mag))));
      chk({req, " sign"}, 32'(disp_neg), 32'(m_neg));
   endtask

   task automatic check_latched(input string req, input int val, input bit neg,
                                input bit ovr, input bit und);
      chk({req, " digits"}, 32'(disp_bcd), 32'(to_bcd(val)));
      chk({req, " sign"}, 32'(disp_neg), 32'(neg));
      chk({req, " over"}, 32'(over_flag), 32'(ovr));
      chk({req, " under"}, 32'(under_flag), 32'(und));
   endtask

   task automatic strobe_and_check(input string req);
      int u;
      strobe();
      u = rounded(m_mag);
      check_latched(req, u, m_neg, u > 19999, u < 1000);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check_latched("R1 reset", 0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_clear();
      hold_mode = 2'b10;
      count(1'b0, 2, 3);
      check_follow("R3 pre-clear 300");
      @(negedge clk); clr = 1'b1; cnt_en = 1'b1; cnt_dn = 1'b0; dec_sel = 3'd0;
      @(negedge clk); clr = 1'b0; cnt_en = 1'b0;
      m_mag = 0; m_neg = 1'b0;
      check_follow("R2 clear over count");
   endtask

   task automatic t_up();
      do_clear();
      count(1'b0, 2, 12);  check_follow("R3 up 1200");
      count(1'b0, 1, 9);   check_follow("R3 up 1290");
      count(1'b0, 1, 1);   check_follow("R3 carry 1300");
      count(1'b0, 0, 5);   check_follow("R8 round up 1305");
   endtask

   task automatic t_down();
      count(1'b1, 0, 5);   check_follow("R4 down 1300");
      count(1'b1, 1, 1);   check_follow("R4 borrow 1290");
      count(1'b1, 3, 1);   check_follow("R4 down 290");
   endtask

   task automatic t_cross();
      do_clear();
      count(1'b0, 0, 3);
      count(1'b1, 1, 1);   check_follow("R5 cross to -7");
      chk("R5 negative sign", 32'(disp_neg), 32'd1);
      count(1'b1, 1, 1);   check_follow("R5 cross back to +3");
      do_clear();
      count(1'b1, 2, 1);   check_follow("R5 zero down to -100");
      count(1'b0, 1, 4);   check_follow("R3 negative magnitude up");
   endtask

   task automatic t_idle();
      int keep = m_mag;
      @(negedge clk); cnt_en = 1'b0; cnt_dn = 1'b1; dec_sel = 3'd2;
      @(negedge clk); dec_sel = 3'd0; cnt_dn = 1'b0;
      @(negedge clk);
      check_follow("R6 enable low");
      count(1'b0, 6, 2);
      count(1'b1, 7, 2);
      check_follow("R6 select out of range");
      chk("R6 magnitude kept", 32'(m_mag), 32'(keep));
   endtask

   task automatic t_sat();
      do_clear();
      for (int k = 5; k >= 0; k--) count(1'b0, k, 9);
      check_follow("R8 saturated rounding 999999");
      count(1'b0, 0, 1);   check_follow("R7 overflow at decade 0");
      count(1'b0, 5, 1);   check_follow("R7 overflow at decade 5");
   endtask

   task automatic t_flags();
      hold_mode = 2'b00;
      do_clear();
      count(1'b0, 5, 1);
      for (int k = 4; k >= 1; k--) count(1'b0, k, 9);
      count(1'b0, 0, 4);
      strobe_and_check("R9 199994 in range");
      count(1'b0, 0, 1);
      strobe_and_check("R9 199995 rounds over");
      do_clear();
      for (int k = 3; k >= 1; k--) count(1'b0, k, 9);
      count(1'b0, 0, 4);
      strobe_and_check("R9 9994 under");
      count(1'b0, 0, 1);
      strobe_and_check("R9 9995 not under");
   endtask

   task automatic t_run();
      int u;
      hold_mode = 2'b11;
      do_clear();
      count(1'b0, 4, 2);
      strobe_and_check("R10 run capture");
      u = rounded(m_mag);
      count(1'b0, 5, 3);
      @(negedge clk);
      check_latched("R10 no strobe stable", u, 1'b0, 1'b0, 1'b0);
      strobe_and_check("R10 second capture");
   endtask

   task automatic t_hold();
      int u; bit n, o, d;
      hold_mode = 2'b00;
      strobe();
      u = rounded(m_mag); n = m_neg; o = u > 19999; d = u < 1000;
      hold_mode = 2'b01;
      do_clear();
      count(1'b1, 1, 3);
      strobe();
      check_latched("R11 hold ignores strobe", u, n, o, d);
      hold_mode = 2'b00;
      strobe_and_check("R11 release then capture");
   endtask

   task automatic t_follow_flags();
      hold_mode = 2'b00;
      do_clear();
      strobe();
      check_latched("R12 base flags", 0, 1'b0, 1'b0, 1'b1);
      hold_mode = 2'b10;
      count(1'b0, 5, 3);
      check_follow("R12 digits follow");
      chk("R12 over waits", 32'(over_flag), 32'd0);
      chk("R12 under waits", 32'(under_flag), 32'd1);
      strobe_and_check("R12 flags on strobe");
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #200_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_clear();
      t_up();
      t_down();
      t_cross();
      t_idle();
      t_sat();
      t_flags();
      t_run();
      t_hold();
      t_follow_flags();
      done = 1'b1;
      finish_run();
   end

endmodule